// File: doc/BRIEF.md
# Serial NOR Flash Read Target

This block is the device side of a serial NOR flash interface, limited to reading. It decodes three read commands: a plain single-line read, a faster single-line read that adds a dummy gap, and a dual-line read that carries both address and data two bits per clock. The host frames each command with an active-low chip select and clocks it with `sclk`. The host sees the block as a read-only array of `2**ADDR_W` bytes. Byte contents are a fixed function of the address, so every returned byte can be predicted.

Incoming bits are taken on the rising edge of `sclk`, and outgoing bits change on the falling edge. The block keeps one address counter, which steps after every complete byte and wraps back to zero at the top of the array. A single command can therefore stream the entire array, and stream it more than once. A `busy` input shows that a program, erase or status-write cycle is running. While it is high, the two faster reads are refused, and the plain read is still served.

The pads are modelled as separate input, output and output-enable signals for the two lines `sio0` and `sio1`. The board or pad ring joins them into bidirectional pins.

Top module: `spi_read_target`

## Requirements
- R1: Every field is sent most significant bit first. Opcode bits are taken from `sio0_in` on rising `sclk` edges. Opcode 0x03 is followed by 24 address bits on `sio0_in`. The first data bit appears at the falling edge right after the last address bit, with no dummy gap.
- R2: Opcode 0x0B is followed by 24 address bits on `sio0_in` and then 8 dummy clocks. Data starts at the falling edge after the eighth dummy clock.
- R3: Opcode 0xBB takes the address in 12 clocks, two bits per clock, with `sio1_in` carrying the higher bit of each pair. Four dummy clocks follow. Data then leaves two bits per clock, with `sio1_out` carrying the higher bit of each pair.
- R4: In the two single-line reads, data is driven on `sio1_out` only and `sio0_oe` stays low. In all reads, output data changes only on falling `sclk` edges.
- R5: The byte at address a equals (a × 29 + 0x3C) mod 256. After each complete byte the address steps by one. After address `2**ADDR_W - 1` it continues at 0.
- R6: Address bits above bit `ADDR_W-1` have no effect on which byte is returned.
- R7: If `busy` is high when the eighth opcode bit is taken, opcodes 0x0B and 0xBB are ignored and nothing is driven until chip select rises. Opcode 0x03 is still served.
- R8: Any other opcode is ignored. No output enable rises until chip select has gone high and a new command has begun.
- R9: Both output enables are low while `cs_n` is high, while `rst_n` is low, and outside the data phase. Raising `cs_n` during data releases the lines at once, and the next command is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; high aborts and resets the command state |
| busy | input | 1 | A write-type cycle is in progress |
| sio0_in | input | 1 | Line 0 input (single-line command, address and dummy input) |
| sio1_in | input | 1 | Line 1 input (used for dual address) |
| sio0_out | output | 1 | Line 0 output value (dual data, lower bit) |
| sio0_oe | output | 1 | Line 0 output enable |
| sio1_out | output | 1 | Line 1 output value (single data, dual higher bit) |
| sio1_oe | output | 1 | Line 1 output enable |

## Verification
On every rising clock the assertions check four things. An output enable may be high only in the data phase. Line 0 is driven only in dual mode. A busy-time fast or dual opcode, or an unknown opcode, sends the block into the ignore state, and it stays there. The address steps by exactly one at every byte boundary. Several behaviours need whole transactions and only the bench scenarios show them: the exact dummy length of each command, bit ordering across the lines, the returned byte values, wrap-around at the top of the array, discarding of upper address bits, and the immediate release when chip select rises mid-byte.

// File: rtl/spi_read_target.sv
module spi_read_target #(
  parameter int ADDR_W     = 8,
  parameter int DUMMY_FAST = 8,
  parameter int DUMMY_DUAL = 4
) (
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic busy,
  input  logic sio0_in,
  input  logic sio1_in,
  output logic sio0_out,
  output logic sio0_oe,
  output logic sio1_out,
  output logic sio1_oe
);
  localparam int ADDR_BITS = 24;
  localparam logic [4:0] LAST_SGL_A = 5'(ADDR_BITS - 1);
  localparam logic [4:0] LAST_DUA_A = 5'(ADDR_BITS / 2 - 1);
  localparam logic [4:0] LAST_FD    = 5'(DUMMY_FAST - 1);
  localparam logic [4:0] LAST_DD    = 5'(DUMMY_DUAL - 1);

  typedef enum logic [2:0] {P_OPC, P_ADDR, P_DUMMY, P_DATA, P_IGNORE} phase_t;

  phase_t            phase;
  logic [7:0]        op_sh;
  logic [4:0]        cnt;
  logic [2:0]        dcnt;
  logic              dual, fast;
  logic [ADDR_W-1:0] addr;

  wire       idle    = cs_n | ~rst_n;
  wire [7:0] op_full = {op_sh[6:0], sio0_in};
  wire [7:0] cur     = 8'(8'(addr) * 8'd29 + 8'h3C);
  wire       byte_end = (phase == P_DATA) && (dcnt == (dual ? 3'd3 : 3'd7));

  always_ff @(posedge sclk or posedge idle) begin
    if (idle) begin
      phase <= P_OPC;
      op_sh <= '0;
      cnt   <= '0;
      dcnt  <= '0;
      dual  <= 1'b0;
      fast  <= 1'b0;
      addr  <= '0;
    end else begin
      case (phase)
        P_OPC: begin
          op_sh <= op_full;
          cnt   <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            case (op_full)
              8'h03: phase <= P_ADDR;
              8'h0B: begin
                phase <= busy ? P_IGNORE : P_ADDR;
                fast  <= 1'b1;
              end
              8'hBB: begin
                phase <= busy ? P_IGNORE : P_ADDR;
                dual  <= 1'b1;
              end
              default: phase <= P_IGNORE;
            endcase
          end
        end
        P_ADDR: begin
          addr <= dual ? ADDR_W'({addr, sio1_in, sio0_in}) : ADDR_W'({addr, sio0_in});
          cnt  <= cnt + 5'd1;
          if (cnt == (dual ? LAST_DUA_A : LAST_SGL_A)) begin
            cnt   <= '0;
            phase <= (dual || fast) ? P_DUMMY : P_DATA;
          end
        end
        P_DUMMY: begin
          cnt <= cnt + 5'd1;
          if (cnt == (dual ? LAST_DD : LAST_FD)) begin
            cnt   <= '0;
            phase <= P_DATA;
          end
        end
        P_DATA: begin
          if (byte_end) begin
            dcnt <= '0;
            addr <= addr + 1'b1;
          end else begin
            dcnt <= dcnt + 3'd1;
          end
        end
        default: phase <= P_IGNORE;
      endcase
    end
  end

  always_ff @(negedge sclk or posedge idle) begin
    if (idle) begin
      sio0_out <= 1'b0;
      sio1_out <= 1'b0;
      sio0_oe  <= 1'b0;
      sio1_oe  <= 1'b0;
    end else if (phase == P_DATA) begin
      sio1_oe <= 1'b1;
      sio0_oe <= dual;
      if (dual) begin
        sio1_out <= cur[3'(3'd7 - {dcnt[1:0], 1'b0})];
        sio0_out <= cur[3'(3'd6 - {dcnt[1:0], 1'b0})];
      end else begin
        sio1_out <= cur[3'(3'd7 - dcnt)];
        sio0_out <= 1'b0;
      end
    end else begin
      sio0_oe <= 1'b0;
      sio1_oe <= 1'b0;
    end
  end

  a_r9_drive_only_in_data: assert property (@(posedge sclk) disable iff (idle)
    sio1_oe |-> (phase == P_DATA));

  a_r4_line0_quiet_single: assert property (@(posedge sclk) disable iff (idle)
    sio0_oe |-> dual);

  a_r7_busy_reject: assert property (@(posedge sclk) disable iff (idle)
    (phase == P_OPC && cnt == 5'd7 && busy && (op_full == 8'h0B || op_full == 8'hBB))
      |=> (phase == P_IGNORE));

  a_r8_unknown_ignored: assert property (@(posedge sclk) disable iff (idle)
    (phase == P_OPC && cnt == 5'd7 && op_full != 8'h03 && op_full != 8'h0B && op_full != 8'hBB)
      |=> (phase == P_IGNORE));

  a_r8_ignore_sticky: assert property (@(posedge sclk) disable iff (idle)
    (phase == P_IGNORE) |=> (phase == P_IGNORE) && !sio0_oe && !sio1_oe);

  a_r5_addr_step: assert property (@(posedge sclk) disable iff (idle)
    byte_end |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: tb/spi_read_target_tb.sv
module spi_read_target_tb;
  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, busy = 1'b0;
  logic sio0_in = 1'b0, sio1_in = 1'b0;
  logic sio0_out, sio0_oe, sio1_out, sio1_oe;
  int total = 0, bad = 0;
  logic early;

  spi_read_target #(.ADDR_W(8)) u_dut (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
    .sio0_in(sio0_in), .sio1_in(sio1_in),
    .sio0_out(sio0_out), .sio0_oe(sio0_oe),
    .sio1_out(sio1_out), .sio1_oe(sio1_oe));

  always #5 sclk = ~sclk;

  // {opcode, address, busy, served}
  localparam logic [33:0] VEC [8] = '{
    {8'h03, 24'h000010, 1'b0, 1'b1},
    {8'h0B, 24'h0000FE, 1'b0, 1'b1},
    {8'hBB, 24'h123456, 1'b0, 1'b1},
    {8'h0B, 24'h000020, 1'b1, 1'b0},
    {8'hBB, 24'h000020, 1'b1, 1'b0},
    {8'h03, 24'h000040, 1'b1, 1'b1},
    {8'h9F, 24'h000000, 1'b0, 1'b0},
    {8'hBB, 24'h0000FF, 1'b0, 1'b1}
  };

  function automatic logic [7:0] exp_byte(input int a);
    return 8'(((a & 255) * 29 + 60) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic b1, input logic b0);
    sio1_in = b1;
    sio0_in = b0;
    @(posedge sclk);
    #1;
    if (sio0_oe || sio1_oe) early = 1'b1;
    @(negedge sclk);
  endtask

  task automatic recv(input bit dl, output logic [7:0] v, output bit oe_ok);
    v = '0;
    oe_ok = 1'b1;
    for (int i = 0; i < (dl ? 4 : 8); i++) begin
      #2;
      if (!sio1_oe || (sio0_oe != dl)) oe_ok = 1'b0;
      v = dl ? {v[5:0], sio1_out, sio0_out} : {v[6:0], sio1_out};
      @(posedge sclk);
      @(negedge sclk);
    end
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a, input logic bz);
    bit dl, fs;
    dl = (op == 8'hBB);
    fs = !(op == 8'h03 || op == 8'hBB);
    @(negedge sclk);
    busy = bz;
    cs_n = 1'b0;
    early = 1'b0;
    for (int i = 7; i >= 0; i--) send(1'b0, op[i]);
    if (dl) begin
      for (int i = 11; i >= 0; i--) send(a[2*i+1], a[2*i]);
      for (int i = 0; i < 4; i++) send(1'b0, 1'b0);
    end else begin
      for (int i = 23; i >= 0; i--) send(1'b0, a[i]);
      if (fs) for (int i = 0; i < 8; i++) send(1'b0, 1'b0);
    end
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    busy = 1'b0;
    @(negedge sclk);
    @(negedge sclk);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input logic bz,
                         input bit served, input int nbytes, input string req);
    logic [7:0] v;
    bit oe_ok, seen;
    header(op, a, bz);
    check(!early, {req, " no drive before data"}, 1, 0);
    if (served) begin
      for (int k = 0; k < nbytes; k++) begin
        recv(op == 8'hBB, v, oe_ok);
        check(v == exp_byte(int'(a) + k) && oe_ok, req, int'(v), int'(exp_byte(int'(a) + k)));
      end
    end else begin
      seen = 1'b0;
      for (int k = 0; k < nbytes * 8; k++) begin
        #2;
        if (sio0_oe || sio1_oe) seen = 1'b1;
        @(posedge sclk);
        @(negedge sclk);
      end
      check(!seen, {req, " ignored"}, int'(seen), 0);
    end
    release_cs();
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit oe_ok;
    repeat (3) @(negedge sclk);
    #1;
    check(!sio0_oe && !sio1_oe, "R9 reset", int'({sio1_oe, sio0_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);

    // R1 R2 R3 R5 R6 R7 R8 table
    for (int i = 0; i < 8; i++)
      run_cmd(VEC[i][33:26], VEC[i][25:2], VEC[i][1], VEC[i][0], 3, $sformatf("R1-R8 vec%0d", i));

    // R9 abort mid-byte, then resync with a fast read
    header(8'h03, 24'h000030, 1'b0);
    recv(1'b0, v, oe_ok);
    check(v == exp_byte(8'h30), "R9 pre-abort byte", int'(v), int'(exp_byte(8'h30)));
    for (int i = 0; i < 3; i++) begin
      @(posedge sclk);
      @(negedge sclk);
    end
    cs_n = 1'b1;
    #1;
    check(!sio0_oe && !sio1_oe, "R9 abort release", int'({sio1_oe, sio0_oe}), 0);
    @(negedge sclk);
    @(negedge sclk);
    run_cmd(8'h0B, 24'h000031, 1'b0, 1'b1, 2, "R9 resync");

    // R5 full-array stream with wrap
    run_cmd(8'h03, 24'h000000, 1'b0, 1'b1, 260, "R5 full wrap");
    // R6 upper bits ignored on single read
    run_cmd(8'h03, 24'hABCD7F, 1'b0, 1'b1, 2, "R6 upper bits");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule